// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits beside a processor core's fetch logic and decides, cycle by cycle, whether the core leaves its current flow for an event handler. Six event sources compete: a reset request, a system break, three synchronous events (reserved instruction, address exception, trap) and a level-sensitive external interrupt. When an event is accepted, the block does four things at one clock edge. It captures the current program counter into a backup PC register. It remembers the interrupt-enable flag and then clears that flag. It pulses a redirect strobe together with a 3-bit cause code.

A return-from-exception strobe undoes the entry. It puts back the enable value that was remembered on entry, pulses a resume strobe and presents the backup PC as the resume address. The core may also write the enable flag directly. All pins are plain control and status signals with no valid/ready pairing. Redirect and resume are single-cycle strobes that the fetch logic must act on, because the block never waits.

The interrupt-enable flag gates four of the sources: reserved instruction, address exception, trap and external interrupt. Reset and system break are always accepted. Synchronous requests that arrive while masked, or while a higher-priority event wins, are remembered until they are taken. The external interrupt is not remembered, so it must stay asserted until it is taken. When a synchronous event and the external interrupt arrive together, the synchronous event runs first. The interrupt then follows once the handler's return re-enables interrupts.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `ie`, `bpc`, `redirect`, `resume` and `cause` are all 0.
- R2: An accepted event raises `redirect` for exactly one cycle, at the clock edge where it is accepted. `cause` carries the event's code: reset 0, system break 1, reserved instruction 2, address exception 3, trap 4, external interrupt 5.
- R3: Acceptance of any event other than reset loads `bpc` with `cur_pc` sampled at that edge, and `ie` reads 0 from that edge on.
- R4: While `ie` is 0, only `reset_req` and `sbi_req` can be accepted. Reserved instruction, address exception, trap and external interrupt are held off.
- R5: A one-cycle pulse on `sbi_req`, `rie_req`, `ae_req` or `trap_req` is remembered until that event is accepted. `ei_req` is not remembered: it is taken only in a cycle where it is high and enabled.
- R6: When several events are eligible in the same cycle, one is accepted, in the order reset, system break, reserved instruction, address exception, trap, external interrupt. The others stay pending per R5.
- R7: `rte` in a cycle with no accepted event pulses `resume` for one cycle and sets `ie` to the value `ie` had just before the most recent entry, not to a constant. `resume_pc` equals `bpc`.
- R8: If a reserved instruction, address exception or trap arrives in the same cycle as the external interrupt, the synchronous event is accepted first. The interrupt is accepted in the first cycle after the return has re-enabled `ie`, provided `ei_req` is still high.
- R9: An accepted `reset_req` overrides every other source in that cycle. It yields cause 0, clears `bpc` and `ie`, and discards every remembered request.
- R10: When an event is accepted in the same cycle as `rte`, the return is discarded: no `resume` pulse, and `ie` is 0.
- R11: `ie_wr` loads `ie` from `ie_wr_val` in a cycle with neither an accepted event nor `rte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's state |
| reset_req | input | 1 | Reset event request (cause 0) |
| sbi_req | input | 1 | System break request, unmaskable (cause 1) |
| rie_req | input | 1 | Reserved instruction exception (cause 2) |
| ae_req | input | 1 | Address exception (cause 3) |
| trap_req | input | 1 | Trap instruction (cause 4) |
| ei_req | input | 1 | External interrupt, level (cause 5) |
| rte | input | 1 | Return-from-exception strobe |
| ie_wr | input | 1 | Direct write strobe for the enable flag |
| ie_wr_val | input | 1 | Value written by `ie_wr` |
| cur_pc | input | PC_W | Return address of the current flow |
| redirect | output | 1 | One-cycle pulse: fetch the handler |
| cause | output | 3 | Code of the accepted event |
| ie | output | 1 | Interrupt-enable flag |
| bpc | output | PC_W | Backup PC holding the saved return address |
| resume | output | 1 | One-cycle pulse: resume at `resume_pc` |
| resume_pc | output | PC_W | Address to resume at |

## Verification
The bench targets several ordering corners:
- A trap or fault that collides with the external interrupt must win. The interrupt must follow immediately after the return, with the same backup PC. A design with the priority inverted, or one that drops the held-off interrupt, shows the wrong cause or no second entry.
- A fault that pulses while masked must be taken once interrupts return. A design that forgets pending requests never redirects, and one that latches the external interrupt redirects a second time, where none is due.
- A return after a system break taken with interrupts masked must leave `ie` at 0. A design that sets `ie` to a constant 1 on return re-enables it.
- A reset event raised with other requests must leave nothing pending.
- A system break that coincides with a return must suppress the resume pulse.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int unsigned NSRC = 6;
  localparam int unsigned CW   = $clog2(NSRC);

  typedef enum logic [CW-1:0] {
    CAUSE_RESET = 3'd0,
    CAUSE_SBRK  = 3'd1,
    CAUSE_RSVD  = 3'd2,
    CAUSE_ADDR  = 3'd3,
    CAUSE_TRAP  = 3'd4,
    CAUSE_EXTI  = 3'd5
  } cause_e;

  // sources gated by the enable flag (bit index == cause code)
  localparam logic [NSRC-1:0] MASKABLE_SRC = 6'b111100;
  // sources remembered until accepted
  localparam logic [NSRC-1:0] HELD_SRC     = 6'b011110;

endpackage

// File: rtl/exc_pending.sv
module exc_pending
  import exc_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter logic [N-1:0] HOLD = HELD_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] req,
  input  logic [N-1:0] grant,
  output logic [N-1:0] eff
);

  logic [N-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else if (flush)
      held_q <= '0;
    else
      held_q <= (held_q | req) & ~grant & HOLD;
  end

  assign eff = req | held_q;

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter logic [N-1:0] MASKABLE = MASKABLE_SRC,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic         enable,
  output logic [N-1:0] grant,
  output logic         any,
  output logic [W-1:0] code
);

  logic [N-1:0] elig;
  logic [N:0]   taken_above;

  assign elig           = req & (~MASKABLE | {N{enable}});
  assign taken_above[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]         = elig[g] & ~taken_above[g];
    assign taken_above[g+1] = taken_above[g] | elig[g];
  end

  assign any = taken_above[N];

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = W'(i);
    end
  end

endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            take_reset,
  input  logic [CW-1:0]   take_code,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            rte,
  input  logic            ie_wr,
  input  logic            ie_wr_val,
  output logic            redirect,
  output logic [CW-1:0]   cause,
  output logic            ie,
  output logic [PC_W-1:0] bpc,
  output logic            resume
);

  logic ie_prior_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect   <= 1'b0;
      cause      <= '0;
      ie         <= 1'b0;
      ie_prior_q <= 1'b0;
      bpc        <= '0;
      resume     <= 1'b0;
    end else begin
      redirect <= take;
      resume   <= 1'b0;
      if (take) cause <= take_code;
      if (take_reset) begin
        ie         <= 1'b0;
        ie_prior_q <= 1'b0;
        bpc        <= '0;
      end else if (take) begin
        ie_prior_q <= ie;
        ie         <= 1'b0;
        bpc        <= cur_pc;
      end else if (rte) begin
        ie     <= ie_prior_q;
        resume <= 1'b1;
      end else if (ie_wr) begin
        ie <= ie_wr_val;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_req,
  input  logic            sbi_req,
  input  logic            rie_req,
  input  logic            ae_req,
  input  logic            trap_req,
  input  logic            ei_req,
  input  logic            rte,
  input  logic            ie_wr,
  input  logic            ie_wr_val,
  input  logic [PC_W-1:0] cur_pc,
  output logic            redirect,
  output logic [2:0]      cause,
  output logic            ie,
  output logic [PC_W-1:0] bpc,
  output logic            resume,
  output logic [PC_W-1:0] resume_pc
);

  logic [NSRC-1:0] raw_req;
  logic [NSRC-1:0] eff_req;
  logic [NSRC-1:0] grant;
  logic            any_grant;
  logic [CW-1:0]   grant_code;

  // bit index equals cause code
  assign raw_req = {ei_req, trap_req, ae_req, rie_req, sbi_req, reset_req};

  exc_pending #(.N(NSRC), .HOLD(HELD_SRC)) u_pending (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (grant[CAUSE_RESET]),
    .req   (raw_req),
    .grant (grant),
    .eff   (eff_req)
  );

  exc_arbiter #(.N(NSRC), .MASKABLE(MASKABLE_SRC)) u_arb (
    .req    (eff_req),
    .enable (ie),
    .grant  (grant),
    .any    (any_grant),
    .code   (grant_code)
  );

  exc_state #(.PC_W(PC_W), .CW(CW)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (any_grant),
    .take_reset (grant[CAUSE_RESET]),
    .take_code  (grant_code),
    .cur_pc     (cur_pc),
    .rte        (rte),
    .ie_wr      (ie_wr),
    .ie_wr_val  (ie_wr_val),
    .redirect   (redirect),
    .cause      (cause),
    .ie         (ie),
    .bpc        (bpc),
    .resume     (resume)
  );

  assign resume_pc = bpc;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reset_req,
  input logic [PC_W-1:0] cur_pc,
  input logic            redirect,
  input logic [2:0]      cause,
  input logic            ie,
  input logic [PC_W-1:0] bpc,
  input logic            resume
);

  assert_cause_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> cause <= 3'd5);

  assert_ie_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !ie);

  assert_bpc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cause != 3'd0) |-> bpc == $past(cur_pc));

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cause >= 3'd2) |-> $past(ie));

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reset_req)) |-> (redirect && cause == 3'd0 && bpc == '0 && !ie));

  assert_entry_beats_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect && resume));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.PC_W(PC_W)) u_entry_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reset_req (reset_req),
  .cur_pc    (cur_pc),
  .redirect  (redirect),
  .cause     (cause),
  .ie        (ie),
  .bpc       (bpc),
  .resume    (resume)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reset_req = 1'b0, sbi_req = 1'b0, rie_req = 1'b0;
  logic            ae_req = 1'b0, trap_req = 1'b0, ei_req = 1'b0;
  logic            rte = 1'b0, ie_wr = 1'b0, ie_wr_val = 1'b0;
  logic [PC_W-1:0] cur_pc = '0;
  logic            redirect, ie, resume;
  logic [2:0]      cause;
  logic [PC_W-1:0] bpc, resume_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl #(.PC_W(PC_W)) i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .sbi_req(sbi_req),
    .rie_req(rie_req), .ae_req(ae_req), .trap_req(trap_req), .ei_req(ei_req),
    .rte(rte), .ie_wr(ie_wr), .ie_wr_val(ie_wr_val), .cur_pc(cur_pc),
    .redirect(redirect), .cause(cause), .ie(ie), .bpc(bpc),
    .resume(resume), .resume_pc(resume_pc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    step(); step();
    chk("R1 ie", 64'(ie), 0);
    chk("R1 bpc", 64'(bpc), 0);
    chk("R1 redirect", 64'(redirect), 0);
    chk("R1 resume", 64'(resume), 0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after release", 64'(redirect), 0);
  endtask

  task automatic t_ie_write();
    ie_wr = 1; ie_wr_val = 1;
    step();
    ie_wr = 0;
    chk("R11 ie written", 64'(ie), 1);
    chk("R11 no redirect", 64'(redirect), 0);
  endtask

  task automatic t_single_ei();
    cur_pc = 32'h100; ei_req = 1;
    step();
    chk("R2 redirect", 64'(redirect), 1);
    chk("R2 cause ei", 64'(cause), 5);
    chk("R3 bpc", 64'(bpc), 32'h100);
    chk("R3 ie cleared", 64'(ie), 0);
    ei_req = 0;
    step();
    chk("R2 single pulse", 64'(redirect), 0);
    rte = 1;
    step();
    rte = 0;
    chk("R7 resume", 64'(resume), 1);
    chk("R7 resume_pc", 64'(resume_pc), 32'h100);
    chk("R7 ie restored", 64'(ie), 1);
    step();
    chk("R7 resume pulse ends", 64'(resume), 0);
  endtask

  task automatic t_masked_pending();
    cur_pc = 32'h200; ei_req = 1;
    step();
    chk("R2 ei entry", 64'(cause), 5);
    cur_pc = 32'h204; rie_req = 1;
    step();
    rie_req = 0;
    chk("R4 rie held off", 64'(redirect), 0);
    step(); step();
    chk("R4 still held off", 64'(redirect), 0);
    ei_req = 0; rte = 1;
    step();
    rte = 0;
    chk("R7 resume", 64'(resume), 1);
    chk("R7 ie back", 64'(ie), 1);
    step();
    chk("R5 pending rie taken", 64'(redirect), 1);
    chk("R5 cause rie", 64'(cause), 2);
    chk("R5 bpc", 64'(bpc), 32'h204);
    rte = 1;
    step();
    rte = 0;
    chk("R7 ie after rie", 64'(ie), 1);
    step();
    chk("R5 ei not latched", 64'(redirect), 0);
  endtask

  task automatic t_simultaneous();
    cur_pc = 32'h300; rie_req = 1; ei_req = 1;
    step();
    rie_req = 0;
    chk("R8 sync first", 64'(cause), 2);
    chk("R8 bpc A", 64'(bpc), 32'h300);
    step();
    chk("R8 ei held during handler", 64'(redirect), 0);
    rte = 1;
    step();
    rte = 0;
    chk("R8 resume", 64'(resume), 1);
    chk("R8 resume_pc A", 64'(resume_pc), 32'h300);
    cur_pc = resume_pc;
    step();
    chk("R8 ei next", 64'(redirect), 1);
    chk("R8 ei cause", 64'(cause), 5);
    chk("R8 bpc A again", 64'(bpc), 32'h300);
    ei_req = 0; rte = 1;
    step();
    rte = 0;
    chk("R7 ie after ei", 64'(ie), 1);
  endtask

  task automatic t_priority_and_collision();
    cur_pc = 32'h400; ae_req = 1; trap_req = 1;
    step();
    ae_req = 0; trap_req = 0;
    chk("R6 ae over trap", 64'(cause), 3);
    sbi_req = 1; rte = 1;
    step();
    sbi_req = 0; rte = 0;
    chk("R10 sbi taken", 64'(redirect), 1);
    chk("R10 cause sbi", 64'(cause), 1);
    chk("R10 no resume", 64'(resume), 0);
    chk("R10 ie low", 64'(ie), 0);
    rte = 1;
    step();
    rte = 0;
    chk("R7 resume", 64'(resume), 1);
    chk("R7 saved ie 0", 64'(ie), 0);
    step();
    chk("R4 trap held", 64'(redirect), 0);
    ie_wr = 1; ie_wr_val = 1;
    step();
    ie_wr = 0;
    chk("R11 ie set", 64'(ie), 1);
    step();
    chk("R6 trap next", 64'(redirect), 1);
    chk("R6 cause trap", 64'(cause), 4);
    rte = 1;
    step();
    rte = 0;
    chk("R7 ie after trap", 64'(ie), 1);
  endtask

  task automatic t_sbi_masked();
    ie_wr = 1; ie_wr_val = 0;
    step();
    ie_wr = 0;
    chk("R11 ie cleared", 64'(ie), 0);
    cur_pc = 32'h500; sbi_req = 1;
    step();
    sbi_req = 0;
    chk("R4 sbi while masked", 64'(cause), 1);
    chk("R4 sbi redirect", 64'(redirect), 1);
    chk("R3 sbi bpc", 64'(bpc), 32'h500);
    rte = 1;
    step();
    rte = 0;
    chk("R7 restores 0", 64'(ie), 0);
    ie_wr = 1; ie_wr_val = 1;
    step();
    ie_wr = 0;
  endtask

  task automatic t_reset_event();
    cur_pc = 32'h600; reset_req = 1; rie_req = 1; ei_req = 1; sbi_req = 1;
    step();
    reset_req = 0; rie_req = 0; ei_req = 0; sbi_req = 0;
    chk("R9 cause reset", 64'(cause), 0);
    chk("R9 redirect", 64'(redirect), 1);
    chk("R9 bpc cleared", 64'(bpc), 0);
    chk("R9 ie cleared", 64'(ie), 0);
    ie_wr = 1; ie_wr_val = 1;
    step();
    ie_wr = 0;
    chk("R9 nothing pending", 64'(redirect), 0);
    step();
    chk("R9 still nothing", 64'(redirect), 0);
  endtask

  initial begin
    t_reset_state();
    t_ie_write();
    t_single_ei();
    t_masked_pending();
    t_simultaneous();
    t_priority_and_collision();
    t_sbi_masked();
    t_reset_event();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule